// File: doc/BRIEF.md
# Receive FIFO with Hysteretic Drain Request

This block is a 128-byte receive buffer. On one side a bus receive controller writes data in 4-byte beats. On the other side a DMA engine drains it one byte at a time. The block tracks how many bytes it holds and how many are free. It raises a drain request toward the DMA engine once free space falls to a programmable low watermark. It then keeps that request up until occupancy has fallen to a small programmable granularity level, so the DMA engine sees one long request rather than a chattering one.

A second gate serves the receive controller. It tells the controller whether a complete burst of the programmed length would fit, so the controller only starts a bus burst it can finish. Two error sources feed one error output, each behind its own mask bit. The first is a sticky overflow flag, set when a beat arrives without room. The second is a live transmit-wait flag, set when the controller has data pending but the burst does not fit. A small write/read port gives access to the watermark, control and status registers.

Top module: `rx_fifo_alarm`

## Requirements
- R1: After reset the FIFO is empty (occupancy 0, free 128, empty high). The drain request and the error output are low. The alarm register (address 0) reads 0. The control register (address 1) reads 0x200, because only the transmit-wait mask is set. The status register (address 2) reads 0.
- R2: The alarm register at address 0 holds a 7-bit watermark in bits 6:0, and bits 31:7 always read as zero. The control register at address 1 holds these fields, and all its other bits read zero:
  - bits 2:0: granularity level;
  - bits 6:4: burst-length code;
  - bit 8: overflow mask;
  - bit 9: transmit-wait mask.
  Address 3 reads zero.
- R3: An accepted push adds 4 to occupancy, and an accepted pop subtracts 1. When both happen in the same cycle the net change is +3. Free space is always 128 minus occupancy. The new counts are visible right after the clock edge on which the push or pop is taken.
- R4: Bytes leave in arrival order. Within a beat, bits 7:0 leave first and bits 31:24 leave last. The pop data output shows the oldest byte before it is popped.
- R5: A push that arrives when fewer than 4 bytes are free is dropped and leaves occupancy unchanged. It sets status bit 0 (overflow), which stays set until 1 is written to status bit 0.
- R6: A pop while the FIFO is empty is ignored. Occupancy stays 0 and the next byte pushed is the next byte shown.
- R7: While the drain request is low, free space less than or equal to the alarm value raises it one cycle later.
- R8: While the drain request is high, it stays high as long as occupancy exceeds the granularity level. It clears one cycle after occupancy is at or below that level.
- R9: The burst-fit output is high exactly when free space is at least 4 times the beat count. Codes 1 to 7 mean that many beats, and code 0 means 8 beats (32 bytes).
- R10: Status bit 1 (transmit wait) reads 1 exactly while the controller reports pending data and the burst-fit output is low.
- R11: The error output is high when the overflow flag is set and its mask is clear, or when the transmit-wait flag is set and its mask is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| push_i | input | 1 | Receive controller writes one beat |
| push_data_i | input | 32 | Beat data, bits 7:0 leave first |
| bus_pend_i | input | 1 | Receive controller has data waiting on the bus |
| burst_ok_o | output | 1 | A full burst fits in the free space |
| pop_i | input | 1 | DMA side removes one byte |
| pop_data_o | output | 8 | Oldest byte in the FIFO |
| empty_o | output | 1 | FIFO holds no data |
| occ_o | output | 8 | Occupancy in bytes |
| free_o | output | 8 | Free space in bytes |
| drain_req_o | output | 1 | Drain request to the DMA engine |
| err_o | output | 1 | Unmasked error |

## Verification
The checker watches the following on every cycle:
- the count steps for a lone push and for an ignored pop on an empty FIFO;
- the set and hold edges of the drain request against the live watermark and granularity level;
- that a push without room always raises the overflow flag;
- that the error output never rises without a flag behind it.

Only the bench scenarios can show the rest:
- byte order across beats;
- the exact clear point of the hysteresis;
- the burst-length decoding, including code 0;
- the mask and write-one-to-clear behaviour seen through the register port.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FIFO_BYTES = 128;
    localparam int BEAT_BYTES = 4;
    localparam int DATA_W     = BEAT_BYTES * 8;
    localparam int CNT_W      = $clog2(FIFO_BYTES) + 1;
    localparam int LVL_W      = $clog2(FIFO_BYTES);
    localparam int GRAN_W     = 3;
    localparam int BCODE_W    = 3;

    typedef enum logic [1:0] {
        REG_ALARM = 2'd0,
        REG_CTRL  = 2'd1,
        REG_STAT  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               txw_mask;
        logic               ovf_mask;
        logic [BCODE_W-1:0] bcode;
        logic [GRAN_W-1:0]  gran;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] used;
        logic [CNT_W-1:0] room;
    } level_t;

    // Bytes needed by one burst; the all-zero code selects the longest burst.
    function automatic logic [CNT_W-1:0] burst_bytes(input logic [BCODE_W-1:0] code);
        logic [CNT_W-1:0] beats;
        beats = (code == '0) ? CNT_W'(2 ** BCODE_W) : CNT_W'(code);
        return beats * CNT_W'(BEAT_BYTES);
    endfunction

    function automatic logic [31:0] ctrl_image(input ctrl_t c);
        logic [31:0] img;
        img        = '0;
        img[2:0]   = c.gran;
        img[6:4]   = c.bcode;
        img[8]     = c.ovf_mask;
        img[9]     = c.txw_mask;
        return img;
    endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             ovf_evt,
    input  logic             txw_live,
    output logic [LVL_W-1:0] alarm_o,
    output ctrl_t            ctrl_o,
    output logic             ovf_o,
    output logic [31:0]      rdata_o
);

    reg_sel_e   sel;
    logic       ovf_clr;

    assign sel     = reg_sel_e'(addr);
    assign ovf_clr = we && (sel == REG_STAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_o         <= '0;
            ctrl_o          <= '0;
            ctrl_o.txw_mask <= 1'b1;
        end else if (we) begin
            case (sel)
                REG_ALARM: alarm_o <= wdata[LVL_W-1:0];
                REG_CTRL: begin
                    ctrl_o.gran     <= wdata[2:0];
                    ctrl_o.bcode    <= wdata[6:4];
                    ctrl_o.ovf_mask <= wdata[8];
                    ctrl_o.txw_mask <= wdata[9];
                end
                default: ;
            endcase
        end
    end

    // Set has priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)          ovf_o <= 1'b0;
        else if (ovf_evt) ovf_o <= 1'b1;
        else if (ovf_clr) ovf_o <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            REG_ALARM: rdata_o[LVL_W-1:0] = alarm_o;
            REG_CTRL:  rdata_o = ctrl_image(ctrl_o);
            REG_STAT:  rdata_o[1:0] = {txw_live, ovf_o};
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = FIFO_BYTES,
    parameter int LANES = BEAT_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  logic [LANES*8-1:0] push_data_i,
    input  logic               pop_i,
    output logic [7:0]         pop_data_o,
    output level_t             lvl_o,
    output logic               ovf_evt_o
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [7:0]       lane [LANES];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] used_q;
    logic             push_ok, pop_ok;

    genvar b;
    generate
        for (b = 0; b < LANES; b++) begin : g_lane
            assign lane[b] = push_data_i[8*b +: 8];
        end
    endgenerate

    assign lvl_o.used = used_q;
    assign lvl_o.room = CNT_W'(DEPTH) - used_q;
    assign push_ok    = push_i && (lvl_o.room >= CNT_W'(LANES));
    assign pop_ok     = pop_i && (used_q != '0);
    assign ovf_evt_o  = push_i && !push_ok;
    assign pop_data_o = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            for (int i = 0; i < LANES; i++) begin
                mem[wptr + PTR_W'(i)] <= lane[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            rptr   <= '0;
            used_q <= '0;
        end else begin
            if (push_ok) wptr <= wptr + PTR_W'(LANES);
            if (pop_ok)  rptr <= rptr + PTR_W'(1);
            used_q <= used_q + (push_ok ? CNT_W'(LANES) : '0) - (pop_ok ? CNT_W'(1) : '0);
        end
    end

endmodule

// File: rtl/rxf_alarm.sv
module rxf_alarm
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  level_t            lvl,
    input  logic [LVL_W-1:0]  alarm,
    input  logic [GRAN_W-1:0] gran,
    output logic              req_o
);

    logic hit_low, hit_drained;

    assign hit_low     = lvl.room <= CNT_W'(alarm);
    assign hit_drained = lvl.used <= CNT_W'(gran);

    always_ff @(posedge clk) begin
        if (rst)        req_o <= 1'b0;
        else if (!req_o) req_o <= hit_low;
        else             req_o <= !hit_drained;
    end

endmodule

// File: rtl/rx_fifo_alarm.sv
module rx_fifo_alarm
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              bus_pend_i,
    output logic              burst_ok_o,
    input  logic              pop_i,
    output logic [7:0]        pop_data_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  occ_o,
    output logic [CNT_W-1:0]  free_o,
    output logic              drain_req_o,
    output logic              err_o
);

    level_t            lvl;
    ctrl_t             ctrl;
    logic [LVL_W-1:0]  alarm_lvl;
    logic [GRAN_W-1:0] gran_lvl;
    logic              ovf_evt, ovf_flag, txw_flag;

    rxf_store #(.DEPTH(FIFO_BYTES), .LANES(BEAT_BYTES)) store_i (
        .clk(clk), .rst(rst),
        .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o),
        .lvl_o(lvl), .ovf_evt_o(ovf_evt)
    );

    rxf_regs regs_i (
        .clk(clk), .rst(rst),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ovf_evt(ovf_evt), .txw_live(txw_flag),
        .alarm_o(alarm_lvl), .ctrl_o(ctrl), .ovf_o(ovf_flag),
        .rdata_o(cfg_rdata)
    );

    assign gran_lvl = ctrl.gran;

    rxf_alarm alarm_i (
        .clk(clk), .rst(rst), .lvl(lvl),
        .alarm(alarm_lvl), .gran(gran_lvl), .req_o(drain_req_o)
    );

    assign occ_o      = lvl.used;
    assign free_o     = lvl.room;
    assign empty_o    = (lvl.used == '0);
    assign burst_ok_o = lvl.room >= burst_bytes(ctrl.bcode);
    assign txw_flag   = bus_pend_i && !burst_ok_o;
    assign err_o      = (ovf_flag && !ctrl.ovf_mask) || (txw_flag && !ctrl.txw_mask);

endmodule

// File: rtl/rx_fifo_alarm_chk.sv
module rx_fifo_alarm_chk
    import rxf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic              pop_i,
    input logic [CNT_W-1:0]  occ_o,
    input logic [CNT_W-1:0]  free_o,
    input logic              drain_req_o,
    input logic              burst_ok_o,
    input logic              err_o,
    input logic [LVL_W-1:0]  alarm_lvl,
    input logic [GRAN_W-1:0] gran_lvl,
    input logic              ovf_flag,
    input logic              txw_flag
);

    assert_push_count_R3: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && free_o >= CNT_W'(BEAT_BYTES)) |=> occ_o == $past(occ_o) + CNT_W'(BEAT_BYTES));

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && occ_o == '0) |=> occ_o == '0);

    assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (push_i && free_o < CNT_W'(BEAT_BYTES)) |=> ovf_flag);

    assert_alarm_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (!drain_req_o && free_o <= CNT_W'(alarm_lvl)) |=> drain_req_o);

    assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (drain_req_o && occ_o > CNT_W'(gran_lvl)) |=> drain_req_o);

    assert_burst_room_R9: assert property (@(posedge clk) disable iff (rst)
        burst_ok_o |-> free_o >= CNT_W'(BEAT_BYTES));

    assert_err_source_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (ovf_flag || txw_flag));

endmodule

bind rx_fifo_alarm rx_fifo_alarm_chk chk_i (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
    .occ_o(occ_o), .free_o(free_o), .drain_req_o(drain_req_o),
    .burst_ok_o(burst_ok_o), .err_o(err_o),
    .alarm_lvl(alarm_lvl), .gran_lvl(gran_lvl),
    .ovf_flag(ovf_flag), .txw_flag(txw_flag)
);

// File: tb/rx_fifo_alarm_tb_top.sv
module rx_fifo_alarm_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        push_i = 1'b0;
    logic [31:0] push_data_i = '0;
    logic        bus_pend_i = 1'b0;
    logic        burst_ok_o;
    logic        pop_i = 1'b0;
    logic [7:0]  pop_data_o;
    logic        empty_o;
    logic [7:0]  occ_o, free_o;
    logic        drain_req_o, err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rx_fifo_alarm dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .push_i(push_i),
        .push_data_i(push_data_i), .bus_pend_i(bus_pend_i),
        .burst_ok_o(burst_ok_o), .pop_i(pop_i), .pop_data_o(pop_data_o),
        .empty_o(empty_o), .occ_o(occ_o), .free_o(free_o),
        .drain_req_o(drain_req_o), .err_o(err_o)
    );

    // {address, write data, expected read-back}
    localparam logic [65:0] REG_VEC [6] = '{
        {2'd0, 32'hFFFF_FFFF, 32'h0000_007F},
        {2'd0, 32'h0000_0020, 32'h0000_0020},
        {2'd1, 32'hFFFF_FFFF, 32'h0000_0377},
        {2'd1, 32'h0000_0204, 32'h0000_0204},
        {2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
        {2'd2, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic push_beat(input logic [31:0] d);
        push_i = 1'b1; push_data_i = d;
        tick();
        push_i = 1'b0;
    endtask

    task automatic pop_byte();
        pop_i = 1'b1;
        tick();
        pop_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [63:0] two_beats;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 occupancy", 32'(occ_o), 32'd0);
        check("R1 free", 32'(free_o), 32'd128);
        check("R1 empty", 32'(empty_o), 32'd1);
        check("R1 drain", 32'(drain_req_o), 32'd0);
        check("R1 err", 32'(err_o), 32'd0);
        reg_read(2'd0, rd); check("R1 alarm reg", rd, 32'h0);
        reg_read(2'd1, rd); check("R1 ctrl reg", rd, 32'h200);
        reg_read(2'd2, rd); check("R1 status reg", rd, 32'h0);

        // R2: register table walk
        for (int i = 0; i < 6; i++) begin
            reg_write(REG_VEC[i][65:64], REG_VEC[i][63:32]);
            reg_read(REG_VEC[i][65:64], rd);
            check("R2 register readback", rd, REG_VEC[i][31:0]);
        end

        // R3/R4: counts and byte order, including simultaneous push and pop
        two_beats = 64'h8877_6655_4433_2211;
        push_beat(two_beats[31:0]);
        check("R3 push count", 32'(occ_o), 32'd4);
        check("R3 free after push", 32'(free_o), 32'd124);
        push_i = 1'b1; push_data_i = two_beats[63:32]; pop_i = 1'b1;
        #1;
        check("R4 first byte", 32'(pop_data_o), 32'h11);
        tick();
        push_i = 1'b0; pop_i = 1'b0;
        check("R3 push and pop", 32'(occ_o), 32'd7);
        for (int k = 1; k < 8; k++) begin
            check("R4 byte order", 32'(pop_data_o), 32'(two_beats[8*k +: 8]));
            pop_byte();
        end
        check("R3 drained", 32'(occ_o), 32'd0);
        check("R3 empty flag", 32'(empty_o), 32'd1);

        // R6: pop on empty ignored
        pop_byte();
        check("R6 empty pop count", 32'(occ_o), 32'd0);
        push_beat(32'hA0B0_C0D0);
        check("R6 pointer unmoved", 32'(pop_data_o), 32'hD0);
        repeat (4) pop_byte();

        // R7/R8/R9: watermark 32, granularity 4, burst code 0
        for (int i = 0; i < 24; i++) push_beat(32'h0101_0101 * 32'(i));
        check("R3 filled", 32'(free_o), 32'd32);
        check("R7 request latency", 32'(drain_req_o), 32'd0);
        tick();
        check("R7 request raised", 32'(drain_req_o), 32'd1);
        check("R9 code0 fits at 32", 32'(burst_ok_o), 32'd1);
        for (int i = 0; i < 91; i++) pop_byte();
        tick();
        check("R8 held above gran", 32'(drain_req_o), 32'd1);
        pop_byte();
        check("R8 one cycle lag", 32'(drain_req_o), 32'd1);
        tick();
        check("R8 cleared at gran", 32'(drain_req_o), 32'd0);
        repeat (4) pop_byte();

        // R9/R10/R11: burst gate and transmit-wait
        for (int i = 0; i < 25; i++) push_beat(32'hCAFE_0000 + 32'(i));
        tick();
        check("R9 code0 blocked at 28", 32'(burst_ok_o), 32'd0);
        bus_pend_i = 1'b1;
        reg_read(2'd2, rd); check("R10 txw status", rd, 32'h2);
        check("R11 txw masked", 32'(err_o), 32'd0);
        reg_write(2'd1, 32'h0000_0004);
        check("R11 txw unmasked", 32'(err_o), 32'd1);
        reg_write(2'd1, 32'h0000_0074);
        check("R9 code7 fits at 28", 32'(burst_ok_o), 32'd1);
        reg_read(2'd2, rd); check("R10 txw clear", rd, 32'h0);
        check("R11 no error", 32'(err_o), 32'd0);
        bus_pend_i = 1'b0;

        // R5/R11: overflow
        for (int i = 0; i < 7; i++) push_beat(32'h5A5A_5A5A);
        check("R5 full", 32'(free_o), 32'd0);
        push_beat(32'hDEAD_BEEF);
        check("R5 dropped", 32'(occ_o), 32'd128);
        reg_read(2'd2, rd); check("R5 sticky set", rd, 32'h1);
        check("R11 overflow err", 32'(err_o), 32'd1);
        reg_write(2'd1, 32'h0000_0174);
        check("R11 overflow masked", 32'(err_o), 32'd0);
        reg_write(2'd2, 32'h0000_0001);
        reg_read(2'd2, rd); check("R5 write-one clear", rd, 32'h0);

        finish_run();
    end

endmodule